// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a reference clock into the sampling-rate enables that a serial transmitter and receiver need. The reference first goes through a shared prescaler. That prescaler either passes every reference cycle or only one in four. Each direction then divides the prescaled ticks by its own divisor. The divisor has a 16-bit integer part and a fraction in sixteenths. The fraction is produced by lengthening some sampling periods by one tick, so that the mean period over sixteen periods is exact.

Each direction also divides its sampling enable by 16, 8 or 4 to give a bit-rate enable. A mode field chooses which. The transmit and receive directions are separate channels, so the two can run at unrelated rates at the same time. Software programs a channel through a byte-wide write port. Any write to a channel restarts that channel's counters, so a new rate begins cleanly.

Top module: `frac_baud_gen`

## Requirements
- R1: While rst_ni is low, all four enable outputs are 0. After reset, each channel holds a divisor of exactly 1 in 16X mode: with the prescaler off, the sampling enable is high in every cycle and the bit enable pulses every 16 cycles.
- R2: With div4_i = 1, the prescaler passes one tick every 4 reference cycles, so every sampling period becomes 4 times longer. With div4_i = 0, every reference cycle is a tick.
- R3: Write address 0 holds the low byte of the integer divisor and address 1 holds the high byte. With a fraction of 0 and an integer N, the sampling enable pulses for one cycle every N ticks (for example, N = 259 gives 259 cycles).
- R4: Address 2 bits [3:0] hold a fraction F in sixteenths. Every sampling period lasts N or N+1 ticks. Any 16 consecutive periods add up to exactly 16*N+F ticks.
- R5: An integer part of 0 is treated as 1.
- R6: Address 2 bits [5:4] select the oversampling mode: 00 gives a bit enable on every 16th sampling pulse, 01 on every 8th and 10 on every 4th. Every bit pulse falls in the same cycle as a sampling pulse.
- R7: Mode code 11 behaves as 16X.
- R8: In 8X mode with an odd fraction, single bit periods can differ by one tick, but two consecutive bit periods always add up to exactly 16*N+F ticks.
- R9: wr_ch_i selects the channel (0 transmit, 1 receive). A write to one channel does not disturb the other channel's outputs.
- R10: A write restarts its channel. The sampling enable is 0 in the cycle after the write. With the prescaler off, the first new sampling pulse comes N cycles after the write edge, and the bit count starts again from zero.
- R11: If a write falls in the same cycle as the end of a sampling period, the restart takes precedence and that period's pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div4_i | input | 1 | 1: prescaler divides the reference by 4 |
| wr_en_i | input | 1 | Register write strobe |
| wr_ch_i | input | 1 | Target channel: 0 transmit, 1 receive |
| wr_addr_i | input | 2 | 0 integer low byte, 1 integer high byte, 2 fraction and mode |
| wr_data_i | input | 8 | Write data |
| tx_samp_o | output | 1 | Transmit sampling enable |
| tx_bit_o | output | 1 | Transmit bit-rate enable |
| rx_samp_o | output | 1 | Receive sampling enable |
| rx_bit_o | output | 1 | Receive bit-rate enable |

## Verification
A register write and the end of a sampling period can land in the same cycle. When they do, the restart must drop that period's pulse.

To force the collision, the receive channel is left at divisor 1. Every cycle then ends a period, so any write coincides with a period end. The bench first confirms the enable is high in the cycle of the write. It then expects the enable to be low for exactly one cycle and high again the cycle after. Meanwhile the untouched transmit channel must keep pulsing without a gap.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    OVS_16  = 2'b00,
    OVS_8   = 2'b01,
    OVS_4   = 2'b10,
    OVS_RSV = 2'b11
  } ovs_e;

  localparam logic [1:0] ADDR_INT_LO = 2'd0;
  localparam logic [1:0] ADDR_INT_HI = 2'd1;
  localparam logic [1:0] ADDR_FRAC   = 2'd2;
  localparam int         MODE_LSB    = 4;
  localparam int         NUM_CH      = 2;
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_en_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pcnt_q <= '0;
    else if (!div_en_i)       pcnt_q <= '0;
    else if (pcnt_q == LAST)  pcnt_q <= '0;
    else                      pcnt_q <= pcnt_q + 1'b1;
  end

  assign tick_o = !div_en_i || (pcnt_q == LAST);

  // R2: divided ticks never come back to back
  a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_en_i && tick_o) |=> (!div_en_i || !tick_o));
endmodule

// File: rtl/baud_regs.sv
module baud_regs import baud_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [1:0]            addr_i,
  input  logic [DATA_W-1:0]     data_i,
  output logic [2*DATA_W-1:0]   int_o,
  output logic [FRAC_W-1:0]     frac_o,
  output ovs_e                  mode_o
);
  logic [DATA_W-1:0] lo_q, hi_q;
  logic [FRAC_W-1:0] frac_q;
  logic [1:0]        mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= DATA_W'(1);
      hi_q   <= '0;
      frac_q <= '0;
      mode_q <= OVS_16;
    end else if (wr_i) begin
      case (addr_i)
        ADDR_INT_LO: lo_q <= data_i;
        ADDR_INT_HI: hi_q <= data_i;
        ADDR_FRAC: begin
          frac_q <= data_i[FRAC_W-1:0];
          mode_q <= data_i[MODE_LSB +: 2];
        end
        default: ;
      endcase
    end
  end

  assign int_o  = {hi_q, lo_q};
  assign frac_o = frac_q;
  assign mode_o = ovs_e'(mode_q);
endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              restart_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              evt_o,
  output logic              samp_o
);
  localparam int CNT_W = INT_W + 1;

  logic [INT_W-1:0]  int_eff;
  logic [CNT_W-1:0]  len_m1, cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   acc_sum;
  logic              extra_q, samp_q;

  assign int_eff = (int_i == '0) ? INT_W'(1) : int_i;
  assign len_m1  = CNT_W'(int_eff) - CNT_W'(1) + CNT_W'(extra_q);
  assign acc_sum = {1'b0, acc_q} + {1'b0, frac_i};
  assign evt_o   = tick_i && !restart_i && (cnt_q == len_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; acc_q <= '0; extra_q <= 1'b0; samp_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0; acc_q <= '0; extra_q <= 1'b0; samp_q <= 1'b0;
    end else begin
      samp_q <= evt_o;
      if (evt_o) begin
        cnt_q   <= '0;
        acc_q   <= acc_sum[FRAC_W-1:0];
        extra_q <= acc_sum[FRAC_W];   // carry stretches next period by one tick
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign samp_o = samp_q;

  // R4: period counter never passes integer+extra
  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(int_eff));
  // R11: restart suppresses the pulse
  a_r11_restart_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !samp_q);
  // R2: pulses only follow a prescaler tick
  a_r2_samp_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_q |-> $past(tick_i));
endmodule

// File: rtl/baud_bit_cnt.sv
module baud_bit_cnt import baud_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic restart_i,
  input  ovs_e mode_i,
  output logic bit_o
);
  logic [3:0] last_idx, bcnt_q;
  logic       bit_q;

  always_comb begin
    case (mode_i)
      OVS_8:   last_idx = 4'd7;
      OVS_4:   last_idx = 4'd3;
      default: last_idx = 4'd15;   // 16X and reserved code
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q <= '0; bit_q <= 1'b0;
    end else if (restart_i) begin
      bcnt_q <= '0; bit_q <= 1'b0;
    end else begin
      bit_q <= evt_i && (bcnt_q == last_idx);
      if (evt_i) bcnt_q <= (bcnt_q == last_idx) ? 4'd0 : bcnt_q + 4'd1;
    end
  end

  assign bit_o = bit_q;

  // R6: sample index stays inside the selected ratio
  a_r6_bcnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcnt_q <= last_idx);
  // R10: restart clears the bit enable
  a_r10_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !bit_q);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen import baud_pkg::*; #(
  parameter int DATA_W  = 8,
  parameter int FRAC_W  = 4,
  parameter int PRE_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div4_i,
  input  logic              wr_en_i,
  input  logic              wr_ch_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              tx_samp_o,
  output logic              tx_bit_o,
  output logic              rx_samp_o,
  output logic              rx_bit_o
);
  localparam int INT_W = 2 * DATA_W;

  logic              tick;
  logic [NUM_CH-1:0] samp, bitr;

  baud_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk_i, .rst_ni, .div_en_i(div4_i), .tick_o(tick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              wr_hit, evt;
    logic [INT_W-1:0]  int_v;
    logic [FRAC_W-1:0] frac_v;
    ovs_e              mode_v;

    assign wr_hit = wr_en_i && (wr_ch_i == 1'(c));

    baud_regs #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_regs (
      .clk_i, .rst_ni, .wr_i(wr_hit), .addr_i(wr_addr_i), .data_i(wr_data_i),
      .int_o(int_v), .frac_o(frac_v), .mode_o(mode_v)
    );

    baud_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
      .clk_i, .rst_ni, .tick_i(tick), .restart_i(wr_hit),
      .int_i(int_v), .frac_i(frac_v), .evt_o(evt), .samp_o(samp[c])
    );

    baud_bit_cnt u_bit (
      .clk_i, .rst_ni, .evt_i(evt), .restart_i(wr_hit),
      .mode_i(mode_v), .bit_o(bitr[c])
    );

    // R6: bit enable always rides on a sampling pulse
    a_r6_bit_on_samp: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bitr[c] |-> samp[c]);
  end

  assign tx_samp_o = samp[0];
  assign tx_bit_o  = bitr[0];
  assign rx_samp_o = samp[1];
  assign rx_bit_o  = bitr[1];
endmodule

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;
  localparam time CLK_P = 20ns;

  logic       clk = 1'b0, rst_ni = 1'b0, div4 = 1'b0;
  logic       wr_en = 1'b0, wr_ch = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tx_samp, tx_bit, rx_samp, rx_bit;
  int         n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  frac_baud_gen dut (
    .clk_i(clk), .rst_ni, .div4_i(div4), .wr_en_i(wr_en), .wr_ch_i(wr_ch),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .tx_samp_o(tx_samp), .tx_bit_o(tx_bit), .rx_samp_o(rx_samp), .rx_bit_o(rx_bit)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic sig(input bit ch, input bit is_bit);
    if (ch) return is_bit ? rx_bit : rx_samp;
    return is_bit ? tx_bit : tx_samp;
  endfunction

  // negedges until the chosen output is seen high
  task automatic wait_pulse(input bit ch, input bit is_bit, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sig(ch, is_bit) && n < 100000);
  endtask

  task automatic interval(input bit ch, input bit is_bit, output int n);
    int d;
    wait_pulse(ch, is_bit, d);
    wait_pulse(ch, is_bit, n);
  endtask

  task automatic wr(input bit ch, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = ch; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_div(input bit ch, input int ival, input int f, input int mode);
    wr(ch, 2'd1, 8'(ival >> 8));
    wr(ch, 2'd2, {2'b00, 2'(mode), 4'(f)});
    wr(ch, 2'd0, 8'(ival));
  endtask

  task automatic t_reset();
    int n;
    repeat (3) @(negedge clk);
    chk("R1 samp in reset", int'(tx_samp | rx_samp), 0);
    chk("R1 bit in reset", int'(tx_bit | rx_bit), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 first samp", int'(tx_samp & rx_samp), 1);
    interval(1'b0, 1'b0, n); chk("R1 default samp period", n, 1);
    interval(1'b1, 1'b1, n); chk("R1 default bit period", n, 16);
  endtask

  task automatic t_collide();
    @(negedge clk);
    chk("R11 precondition rx pulsing", int'(rx_samp), 1);
    wr_en = 1'b1; wr_ch = 1'b1; wr_addr = 2'd0; wr_data = 8'd1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R11 pulse dropped on write", int'(rx_samp), 0);
    chk("R9 tx untouched by rx write", int'(tx_samp), 1);
    @(negedge clk);
    chk("R10 rx resumes after one cycle", int'(rx_samp), 1);
  endtask

  task automatic t_restart_int();
    int n;
    set_div(1'b0, 5, 0, 0);
    chk("R10 samp low after write", int'(tx_samp), 0);
    wait_pulse(1'b0, 1'b0, n); chk("R10 first pulse delay", n, 5);
    wait_pulse(1'b0, 1'b0, n); chk("R3 integer period 5", n, 5);
    interval(1'b1, 1'b0, n);   chk("R9 rx still at 1", n, 1);
    set_div(1'b0, 259, 0, 0);
    interval(1'b0, 1'b0, n);   chk("R3 integer period 259", n, 259);
  endtask

  task automatic t_frac();
    int n, sum = 0, longs = 0, odd = 0;
    set_div(1'b0, 3, 5, 0);
    wait_pulse(1'b0, 1'b0, n);
    for (int i = 0; i < 16; i++) begin
      wait_pulse(1'b0, 1'b0, n);
      sum += n;
      if (n == 4) longs++; else if (n != 3) odd++;
    end
    chk("R4 sum of 16 periods", sum, 53);
    chk("R4 stretched periods", longs, 5);
    chk("R4 periods outside N..N+1", odd, 0);
    set_div(1'b0, 0, 0, 0);
    interval(1'b0, 1'b0, n); chk("R5 zero integer acts as 1", n, 1);
  endtask

  task automatic t_prescale();
    int n;
    set_div(1'b0, 3, 0, 0);
    div4 = 1'b1;
    interval(1'b0, 1'b0, n); chk("R2 tx period with div4", n, 12);
    interval(1'b1, 1'b0, n); chk("R2 rx period with div4", n, 4);
    div4 = 1'b0;
    interval(1'b0, 1'b0, n); chk("R2 tx period without div4", n, 3);
  endtask

  task automatic t_modes();
    int n;
    set_div(1'b0, 2, 0, 1);
    interval(1'b0, 1'b1, n); chk("R6 8X bit period", n, 16);
    chk("R6 bit coincides with samp", int'(tx_samp), 1);
    set_div(1'b0, 2, 0, 2);
    interval(1'b0, 1'b1, n); chk("R6 4X bit period", n, 8);
    set_div(1'b0, 2, 0, 0);
    interval(1'b0, 1'b1, n); chk("R6 16X bit period", n, 32);
    set_div(1'b0, 2, 0, 3);
    interval(1'b0, 1'b1, n); chk("R7 reserved mode as 16X", n, 32);
  endtask

  task automatic t_jitter();
    int d, b1, b2;
    set_div(1'b0, 2, 3, 1);
    wait_pulse(1'b0, 1'b1, d);
    wait_pulse(1'b0, 1'b1, b1);
    wait_pulse(1'b0, 1'b1, b2);
    chk("R8 two bits sum", b1 + b2, 35);
    chk("R8 bit within one tick", int'((b1 == 17 || b1 == 18) && (b2 == 17 || b2 == 18)), 1);
  endtask

  task automatic t_indep();
    int n;
    set_div(1'b0, 7, 0, 0);
    set_div(1'b1, 3, 0, 0);
    interval(1'b0, 1'b0, n); chk("R9 tx own rate", n, 7);
    interval(1'b1, 1'b0, n); chk("R9 rx own rate", n, 3);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_collide();
    t_restart_int();
    t_frac();
    t_prescale();
    t_modes();
    t_jitter();
    t_indep();
    summary();
  end
endmodule